// File: doc/BRIEF.md
# Serpentine Tiled Texture Address Generator

This block turns a pixel coordinate into the byte offset of that pixel inside a three-level tiled texture at 32 bits per pixel. The smallest unit is a 64-byte micro-tile of 4x4 pixels stored in raster order. Sixteen micro-tiles, also in raster order, form a 1 KB subtile of 16x16 pixels. Four subtiles form a 4 KB tile of 32x32 pixels. Row zero of the image (y = 0) is the bottom edge, and the bottom-left corner is the start of memory.

Tiles are laid out in a serpentine pattern. On tile rows with an even index, tiles run left to right and the four subtiles of a tile are stored bottom-left, top-left, top-right, bottom-right. On odd tile rows, tiles run right to left and the subtiles are stored top-right, bottom-right, bottom-left, top-left. The image extent is given in whole tiles. A coordinate outside that extent raises an error flag instead of producing an address.

The block is a single registered stage. Every request strobe yields one result strobe on the following clock edge, so it can sit inline in a texture fetch pipeline that issues one address per cycle.

Top module: `tt_tile_addr_gen`

## Requirements
- R1: `out_valid` is high exactly in the cycle after each cycle in which `in_valid` was sampled high; the result belongs to that request.
- R2: Offset bits [5:2] equal {y[1:0], x[1:0]} (pixel within the micro-tile, row-major, 4 bytes per pixel), and bits [1:0] are zero.
- R3: Offset bits [9:6] equal {y[3:2], x[3:2]} (micro-tile within the subtile, row-major).
- R4: On even tile rows (y[5] = 0), offset bits [11:10] give the subtile slot: bottom-left (x[4]=0, y[4]=0) is 0, top-left is 1, top-right is 2, bottom-right is 3.
- R5: On odd tile rows (y[5] = 1), offset bits [11:10] give top-right 0, bottom-right 1, bottom-left 2, top-left 3.
- R6: On even tile rows, offset bits [OFF_W-1:12] equal ty*W + tx, where tx = x>>5, ty = y>>5 and W = `width_tiles`.
- R7: On odd tile rows, offset bits [OFF_W-1:12] equal ty*W + (W-1-tx).
- R8: When tx >= `width_tiles` or ty >= `height_tiles`, `out_err` is 1 and `out_offset` is 0; otherwise `out_err` is 0.
- R9: While `rst` is high on a clock edge, `out_valid` is 0 after that edge.
- R10: The pixel at x = 0, y = 0 maps to offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| pix_x | input | COORD_W | Pixel column, 0 at the left edge |
| pix_y | input | COORD_W | Pixel row, 0 at the bottom edge |
| width_tiles | input | TCNT_W | Image width in 32-pixel tiles |
| height_tiles | input | TCNT_W | Image height in 32-pixel tiles |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_offset | output | OFF_W | Byte offset of the pixel, zero on error |
| out_err | output | 1 | Coordinate outside the configured extent |

## Verification
The assertions assume that the coordinate and extent inputs carry known values in every cycle with `in_valid` high, and that reset is high on the first clock edge. They check the address fields only for requests that fall inside the extent. The bench drives every input at the falling edge, so values are always settled at the sampling edge. It holds reset from time zero and covers both in-range and out-of-range requests, with idle gaps and a change of extent between phases.

// File: rtl/tt_addr_pkg.sv
package tt_addr_pkg;

    // Byte-size exponents of each layout level at 32 bits per pixel
    localparam int PIX_LG   = 2;   // 4 bytes per pixel
    localparam int MICRO_LG = 6;   // 64-byte micro-tile
    localparam int SUB_LG   = 10;  // 1 KB subtile
    localparam int TILE_LG  = 12;  // 4 KB tile

    // Pixel-coordinate exponents of each level edge
    localparam int MICRO_PIX_LG = 2;  // 4 pixels
    localparam int SUB_PIX_LG   = 4;  // 16 pixels
    localparam int TILE_PIX_LG  = 5;  // 32 pixels

    // Quadrant of a tile, coded {x half, y half}; y half 0 is the bottom
    typedef enum logic [1:0] {
        QUAD_BL = 2'b00,
        QUAD_TL = 2'b01,
        QUAD_BR = 2'b10,
        QUAD_TR = 2'b11
    } quad_e;

    // Byte position inside one tile: subtile slot, micro-tile, pixel
    typedef struct packed {
        logic [1:0] slot;
        logic [3:0] micro;
        logic [3:0] pix;
    } intra_t;

    // Storage slot of a quadrant for the given tile-row parity
    function automatic logic [1:0] quad_slot(input quad_e q, input logic odd_row);
        logic [1:0] s;
        if (!odd_row) begin
            unique case (q)
                QUAD_BL: s = 2'd0;
                QUAD_TL: s = 2'd1;
                QUAD_TR: s = 2'd2;
                default: s = 2'd3;
            endcase
        end else begin
            unique case (q)
                QUAD_TR: s = 2'd0;
                QUAD_BR: s = 2'd1;
                QUAD_BL: s = 2'd2;
                default: s = 2'd3;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/tt_intra_tile.sv
module tt_intra_tile
    import tt_addr_pkg::*;
(
    input  logic [TILE_PIX_LG-1:0] lx,
    input  logic [TILE_PIX_LG-1:0] ly,
    input  logic                   odd_row,
    output intra_t                 loc
);
    quad_e quad;

    always_comb begin
        quad      = quad_e'({lx[SUB_PIX_LG], ly[SUB_PIX_LG]});
        loc.slot  = quad_slot(quad, odd_row);
        loc.micro = {ly[SUB_PIX_LG-1:MICRO_PIX_LG], lx[SUB_PIX_LG-1:MICRO_PIX_LG]};
        loc.pix   = {ly[MICRO_PIX_LG-1:0], lx[MICRO_PIX_LG-1:0]};
    end
endmodule

// File: rtl/tt_bounds_check.sv
module tt_bounds_check #(
    parameter int TC_W   = 11,
    parameter int TCNT_W = 11,
    localparam int CW    = (TC_W > TCNT_W) ? TC_W : TCNT_W
) (
    input  logic [TC_W-1:0]   tx,
    input  logic [TC_W-1:0]   ty,
    input  logic [TCNT_W-1:0] width_tiles,
    input  logic [TCNT_W-1:0] height_tiles,
    output logic              err
);
    logic x_out, y_out;

    always_comb begin
        x_out = CW'(tx) >= CW'(width_tiles);
        y_out = CW'(ty) >= CW'(height_tiles);
        err   = x_out | y_out;
    end
endmodule

// File: rtl/tt_tile_locator.sv
module tt_tile_locator #(
    parameter int TC_W   = 11,
    parameter int TCNT_W = 11,
    localparam int IDX_W = TC_W + TCNT_W,
    localparam int CW    = (TC_W > TCNT_W) ? TC_W : TCNT_W
) (
    input  logic [TC_W-1:0]   tx,
    input  logic [TC_W-1:0]   ty,
    input  logic [TCNT_W-1:0] width_tiles,
    output logic              odd_row,
    output logic [IDX_W-1:0]  tile_idx
);
    logic [CW-1:0]     col_rev;
    logic [TCNT_W-1:0] col;
    logic [IDX_W-1:0]  row_base;

    always_comb begin
        odd_row  = ty[0];
        // Reversed column on odd rows; only meaningful while tx < width
        col_rev  = CW'(width_tiles) - CW'(1) - CW'(tx);
        col      = odd_row ? TCNT_W'(col_rev) : TCNT_W'(tx);
        row_base = IDX_W'(ty) * IDX_W'(width_tiles);
        tile_idx = row_base + IDX_W'(col);
    end
endmodule

// File: rtl/tt_tile_addr_gen.sv
module tt_tile_addr_gen
    import tt_addr_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int TCNT_W  = 11,
    localparam int TC_W   = COORD_W - TILE_PIX_LG,
    localparam int IDX_W  = TC_W + TCNT_W,
    localparam int OFF_W  = IDX_W + TILE_LG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [TCNT_W-1:0]  width_tiles,
    input  logic [TCNT_W-1:0]  height_tiles,
    output logic               out_valid,
    output logic [OFF_W-1:0]   out_offset,
    output logic               out_err
);
    logic [TC_W-1:0]  tx, ty;
    logic             odd_row;
    logic [IDX_W-1:0] tile_idx;
    intra_t           loc;
    logic             err;
    logic [OFF_W-1:0] offset_next;

    assign tx = pix_x[COORD_W-1:TILE_PIX_LG];
    assign ty = pix_y[COORD_W-1:TILE_PIX_LG];

    tt_tile_locator #(.TC_W(TC_W), .TCNT_W(TCNT_W)) u_locator (
        .tx          (tx),
        .ty          (ty),
        .width_tiles (width_tiles),
        .odd_row     (odd_row),
        .tile_idx    (tile_idx)
    );

    tt_intra_tile u_intra (
        .lx      (pix_x[TILE_PIX_LG-1:0]),
        .ly      (pix_y[TILE_PIX_LG-1:0]),
        .odd_row (odd_row),
        .loc     (loc)
    );

    tt_bounds_check #(.TC_W(TC_W), .TCNT_W(TCNT_W)) u_bounds (
        .tx           (tx),
        .ty           (ty),
        .width_tiles  (width_tiles),
        .height_tiles (height_tiles),
        .err          (err)
    );

    always_comb begin
        offset_next = err ? '0 : {tile_idx, loc, {PIX_LG{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_offset <= '0;
            out_err    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_offset <= offset_next;
                out_err    <= err;
            end
        end
    end
endmodule

// File: rtl/tt_tile_addr_gen_chk.sv
module tt_tile_addr_gen_chk #(
    parameter int COORD_W = 16,
    parameter int TCNT_W  = 11,
    localparam int TC_W   = COORD_W - 5,
    localparam int IDX_W  = TC_W + TCNT_W,
    localparam int OFF_W  = IDX_W + 12,
    localparam int CW     = (TC_W > TCNT_W) ? TC_W : TCNT_W
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic [TCNT_W-1:0]  width_tiles,
    input logic [TCNT_W-1:0]  height_tiles,
    input logic               out_valid,
    input logic [OFF_W-1:0]   out_offset,
    input logic               out_err
);
    logic             in_range;
    logic [IDX_W-1:0] area;

    always_comb begin
        in_range = (CW'(pix_x[COORD_W-1:5]) < CW'(width_tiles)) &&
                   (CW'(pix_y[COORD_W-1:5]) < CW'(height_tiles));
        area     = IDX_W'(width_tiles) * IDX_W'(height_tiles);
    end

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid);
    a_r2_pixel_field: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_range) |=> out_offset[5:0] == {$past(pix_y[1:0]), $past(pix_x[1:0]), 2'b00});
    a_r3_micro_field: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_range) |=> out_offset[9:6] == {$past(pix_y[3:2]), $past(pix_x[3:2])});
    a_r4_even_bl_first: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_range && !pix_y[5] && !pix_x[4] && !pix_y[4]) |=> out_offset[11:10] == 2'd0);
    a_r5_odd_tr_first: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_range && pix_y[5] && pix_x[4] && pix_y[4]) |=> out_offset[11:10] == 2'd0);
    a_r6_inside_area: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_range) |=> out_offset[OFF_W-1:12] < $past(area));
    a_r8_flag_raised: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_range) |=> (out_err && out_offset == '0));
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_range) |=> !out_err);
endmodule

bind tt_tile_addr_gen tt_tile_addr_gen_chk #(.COORD_W(COORD_W), .TCNT_W(TCNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .pix_x        (pix_x),
    .pix_y        (pix_y),
    .width_tiles  (width_tiles),
    .height_tiles (height_tiles),
    .out_valid    (out_valid),
    .out_offset   (out_offset),
    .out_err      (out_err)
);

// File: tb/tt_tile_addr_gen_bench.sv
`timescale 1ns/1ps
module tt_tile_addr_gen_bench;
    localparam int COORD_W = 16;
    localparam int TCNT_W  = 11;
    localparam int OFF_W   = COORD_W - 5 + TCNT_W + 12;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [COORD_W-1:0] pix_x = '0;
    logic [COORD_W-1:0] pix_y = '0;
    logic [TCNT_W-1:0]  width_tiles = '0;
    logic [TCNT_W-1:0]  height_tiles = '0;
    logic               out_valid;
    logic [OFF_W-1:0]   out_offset;
    logic               out_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tt_tile_addr_gen #(.COORD_W(COORD_W), .TCNT_W(TCNT_W)) u_tt_tile_addr_gen (
        .clk, .rst, .in_valid, .pix_x, .pix_y, .width_tiles, .height_tiles,
        .out_valid, .out_offset, .out_err
    );

    typedef struct {
        bit     v;
        bit     e;
        bit     odd;
        bit     origin;
        longint off;
    } exp_t;

    exp_t exp_q[$];

    // Behavioural model: walk the layout levels with integer arithmetic
    function automatic exp_t model(bit v, int x, int y, int w, int h);
        exp_t r;
        int tx, ty, col, lx, ly, name, slot;
        int odd_order[4] = '{2, 3, 0, 1};  // names: 0 BL, 1 TL, 2 TR, 3 BR
        r.v = v;
        tx = x / 32;
        ty = y / 32;
        r.e = (tx >= w) || (ty >= h);
        r.odd = (ty % 2) == 1;
        r.origin = v && (x == 0) && (y == 0);
        col = r.odd ? (w - 1 - tx) : tx;
        lx = x % 32;
        ly = y % 32;
        if (lx >= 16) name = (ly >= 16) ? 2 : 3;
        else          name = (ly >= 16) ? 1 : 0;
        slot = name;
        if (r.odd) begin
            for (int k = 0; k < 4; k++) if (odd_order[k] == name) slot = k;
        end
        r.off = longint'(ty * w + col) * 4096 + longint'(slot) * 1024
              + longint'(((ly % 16) / 4) * 4 + (lx % 16) / 4) * 64
              + longint'((ly % 4) * 4 + (lx % 4)) * 4;
        if (r.e) r.off = 0;
        return r;
    endfunction

    task automatic chk(string tag, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic check_out();
        exp_t ex;
        longint act;
        if (exp_q.size() == 0) return;
        ex = exp_q.pop_front();
        act = longint'(out_offset);
        chk("R1 out_valid", longint'(out_valid), longint'(ex.v));
        if (ex.v && out_valid) begin
            chk("R8 out_err", longint'(out_err), longint'(ex.e));
            if (ex.e) begin
                chk("R8 offset zero on error", act, 0);
            end else begin
                chk("R2 pixel field", act & 64'h3f, ex.off & 64'h3f);
                chk("R3 micro field", (act >> 6) & 64'hf, (ex.off >> 6) & 64'hf);
                if (ex.odd) begin
                    chk("R5 odd-row subtile slot", (act >> 10) & 3, (ex.off >> 10) & 3);
                    chk("R7 odd-row tile index", act >> 12, ex.off >> 12);
                end else begin
                    chk("R4 even-row subtile slot", (act >> 10) & 3, (ex.off >> 10) & 3);
                    chk("R6 even-row tile index", act >> 12, ex.off >> 12);
                end
                if (ex.origin) chk("R10 origin offset", act, 0);
            end
        end
    endtask

    task automatic step(bit v, int x, int y, int w, int h);
        @(negedge clk);
        check_out();
        in_valid     = v;
        pix_x        = COORD_W'(x);
        pix_y        = COORD_W'(y);
        width_tiles  = TCNT_W'(w);
        height_tiles = TCNT_W'(h);
        exp_q.push_back(model(v, x, y, w, h));
    endtask

    initial begin
        int seed;
        int w, h;
        repeat (3) @(negedge clk);
        chk("R9 out_valid in reset", longint'(out_valid), 0);
        chk("R9 out_err in reset", longint'(out_err), 0);
        rst = 1'b0;
        w = 5;
        h = 4;
        step(0, 0, 0, w, h);
        // R10 origin, then one pixel of each quadrant on an even row
        step(1, 0, 0, w, h);
        step(1, 3, 0, w, h);
        step(1, 0, 3, w, h);
        step(1, 5, 20, w, h);    // TL, R4
        step(1, 20, 20, w, h);   // TR, R4
        step(1, 20, 5, w, h);    // BR, R4
        step(1, 37, 9, w, h);    // second tile, R6
        // odd row quadrants and reversed columns, R5 and R7
        step(1, 17, 49, w, h);   // TR
        step(1, 17, 33, w, h);   // BR
        step(1, 2, 33, w, h);    // BL
        step(1, 2, 50, w, h);    // TL
        step(1, 159, 63, w, h);  // last column, odd row
        step(1, 0, 127, w, h);   // first column, row 3 (odd)
        step(1, 159, 64, w, h);  // last column, row 2 (even)
        // extent boundaries, R8
        step(1, 160, 0, w, h);
        step(1, 0, 128, w, h);
        step(1, 9000, 9000, w, h);
        step(0, 1, 1, w, h);
        step(1, 159, 127, w, h);
        // back-to-back with gaps, two extents
        seed = 12345;
        for (int ph = 0; ph < 2; ph++) begin
            if (ph == 1) begin
                w = 3;
                h = 7;
            end
            for (int i = 0; i < 300; i++) begin
                int x, y, vv;
                seed = seed * 1103515245 + 12345;
                x = (seed >>> 8) & 32'h7fff;
                seed = seed * 1103515245 + 12345;
                y = (seed >>> 8) & 32'h7fff;
                seed = seed * 1103515245 + 12345;
                vv = ((seed >>> 16) & 7) != 0;
                if (((seed >>> 20) & 7) != 0) begin
                    x = x % (w * 32);
                    y = y % (h * 32);
                end else begin
                    x = x % (w * 32 + 40);
                    y = y % (h * 32 + 40);
                end
                step(vv[0], x, y, w, h);
            end
        end
        step(0, 0, 0, w, h);
        step(0, 0, 0, w, h);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule